// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 10-bit multiplying digital-to-analog converter. A processor writes a code into an input latch over an 8-bit or 10-bit data bus, using four active-level controls: chip select, write, byte select and transfer. A separate transfer operation then copies the whole latched code into a DAC register. The DAC register drives the converter ladder and keeps its value while the next code is assembled, so several converters can be preloaded and then updated together by one shared transfer strobe.

The input latch has an upper 8-bit part and a lower 2-bit part. A write with byte select high loads all ten bits. A write with byte select low replaces only the two low bits, and takes them from the two most significant bus lines, which suits a left-justified 8-bit bus. The level-actuated latch behaviour is modelled synchronously: each clock the control levels are decoded into one bus action, a state machine registers that action, and the storage loads in the same edge.

The control decoder names the following actions. HOLD means nothing is stored. LOAD_ALL is a write with byte select high. LOAD_LOW is a write with byte select low and transfer inactive. XFER is a transfer with chip select high, so no latch load takes place. LOAD_XFER is a low-bit write and a transfer in the same cycle, which gives flow-through. The next action is decoded from the inputs on every cycle, so any action can follow any other.

Top module: `dac_dbuf_front`

## Requirements
- R1: While reset `rst_n` is low, both `latch_code` and `dac_code` read all zeros, and they still read all zeros in the first cycle after reset is released.
- R2: If `cs_n` is high on a clock edge, `latch_code` does not change at that edge.
- R3: If `wr_n` is high on a clock edge, `latch_code` does not change at that edge.
- R4: If `cs_n`=0, `wr_n`=0 and `bsel`=1 on an edge, then after that edge `latch_code` equals `din[9:0]`.
- R5: If `cs_n`=0, `wr_n`=0 and `bsel`=0 on an edge, then `latch_code[9:2]` is unchanged and `latch_code[1:0]` takes `din[9:8]`.
- R6: If `xfer_n`=0, `wr_n`=0 and `bsel`=0 on an edge, `dac_code` takes the latch value. Chip select plays no part in this, so with `cs_n`=1 the value copied is the latch contents held before the edge.
- R7: If `xfer_n`=1, `wr_n`=1 or `bsel`=1 on an edge, `dac_code` holds its value, including while the input latch is being loaded.
- R8: When a low-bit write and a transfer occur in the same cycle (all four controls active, byte select low), `dac_code` equals the newly written `latch_code` after that edge.
- R9: A write with `bsel`=1 carrying byte B on `din[9:2]`, followed by a write with `bsel`=0 carrying byte C on `din[9:2]`, leaves `latch_code` = {B, C[7:6]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; it gates the write |
| wr_n | input | 1 | Write strobe, active low |
| bsel | input | 1 | Byte select: 1 loads all ten bits, 0 loads only the low two bits and allows a transfer |
| xfer_n | input | 1 | Transfer strobe, active low |
| din | input | 10 | Data bus; bit 9 is the MSB, and an 8-bit bus connects to bits 9..2 |
| latch_code | output | 10 | Input latch contents |
| dac_code | output | 10 | DAC register code that drives the ladder |

## Verification
The assertions assume that every control level and the data bus come from logic clocked by `clk`, so each input is settled and known for a full cycle around the sampling edge. The bench keeps to this assumption by changing all inputs only on the falling edge and reading the outputs on the following falling edge. Each step therefore applies exactly one decoded action at one rising edge, and the bench can work out the expected latch and DAC values from that action alone.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_LOAD_ALL  = 3'd1,
        ST_LOAD_LOW  = 3'd2,
        ST_XFER      = 3'd3,
        ST_LOAD_XFER = 3'd4
    } bus_act_e;
endpackage

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dac_dbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     wr_n,
    input  logic     bsel,
    input  logic     xfer_n,
    output logic     ld_high,
    output logic     ld_low,
    output logic     low_from_top,
    output logic     do_xfer,
    output bus_act_e act_q
);
    bus_act_e act_d;

    // decode the control levels into one action
    always_comb begin
        if (!wr_n && !bsel && !xfer_n)
            act_d = cs_n ? ST_XFER : ST_LOAD_XFER;
        else if (!wr_n && !cs_n)
            act_d = bsel ? ST_LOAD_ALL : ST_LOAD_LOW;
        else
            act_d = ST_HOLD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= ST_HOLD;
        else        act_q <= act_d;
    end

    // output decode
    always_comb begin
        ld_high      = 1'b0;
        ld_low       = 1'b0;
        low_from_top = 1'b0;
        do_xfer      = 1'b0;
        unique case (act_d)
            ST_HOLD: ;
            ST_LOAD_ALL: begin
                ld_high = 1'b1;
                ld_low  = 1'b1;
            end
            ST_LOAD_LOW: begin
                ld_low       = 1'b1;
                low_from_top = 1'b1;
            end
            ST_XFER: do_xfer = 1'b1;
            ST_LOAD_XFER: begin
                ld_low       = 1'b1;
                low_from_top = 1'b1;
                do_xfer      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dac_dbuf_latch.sv
module dac_dbuf_latch #(
    parameter int CODE_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_high,
    input  logic              ld_low,
    input  logic              low_from_top,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] latch_d
);
    localparam int HIGH_W = CODE_W - LOW_W;

    logic [HIGH_W-1:0] high_q, high_d;
    logic [LOW_W-1:0]  low_q,  low_d;

    always_comb begin
        high_d = ld_high ? din[CODE_W-1:LOW_W] : high_q;
        if (!ld_low)
            low_d = low_q;
        else if (low_from_top)
            low_d = din[CODE_W-1 -: LOW_W];
        else
            low_d = din[LOW_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_q <= '0;
            low_q  <= '0;
        end else begin
            high_q <= high_d;
            low_q  <= low_d;
        end
    end

    assign latch_q = {high_q, low_q};
    assign latch_d = {high_d, low_d};
endmodule

// File: rtl/dac_dbuf_reg.sv
module dac_dbuf_reg #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_xfer,
    input  logic [CODE_W-1:0] src,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (do_xfer) code_q <= src;
    end
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              bsel,
    input  logic              xfer_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] latch_code,
    output logic [CODE_W-1:0] dac_code
);
    logic              ld_high, ld_low, low_from_top, do_xfer;
    logic [CODE_W-1:0] latch_next;
    bus_act_e          act_q;

    dac_dbuf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .bsel(bsel), .xfer_n(xfer_n), .ld_high(ld_high), .ld_low(ld_low),
        .low_from_top(low_from_top), .do_xfer(do_xfer), .act_q(act_q)
    );

    dac_dbuf_latch #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_high(ld_high), .ld_low(ld_low),
        .low_from_top(low_from_top), .din(din),
        .latch_q(latch_code), .latch_d(latch_next)
    );

    // transfer takes the value the latch holds after this edge
    dac_dbuf_reg #(.CODE_W(CODE_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .do_xfer(do_xfer),
        .src(latch_next), .code_q(dac_code)
    );
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              bsel,
    input logic              xfer_n,
    input logic [CODE_W-1:0] din,
    input logic [CODE_W-1:0] latch_code,
    input logic [CODE_W-1:0] dac_code,
    input bus_act_e          act_q
);
    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(latch_code));
    // R3
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(latch_code));
    // R4
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && bsel) |=> latch_code == $past(din));
    // R5
    low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !bsel) |=>
            (latch_code[CODE_W-1:LOW_W] == $past(latch_code[CODE_W-1:LOW_W]))
            && (latch_code[LOW_W-1:0] == $past(din[CODE_W-1 -: LOW_W])));
    // R6
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !wr_n && !bsel && !xfer_n) |=> dac_code == $past(latch_code));
    // R7
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_n || wr_n || bsel) |=> $stable(dac_code));
    // R8
    flow_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == ST_LOAD_XFER) |-> dac_code == latch_code);
endmodule

bind dac_dbuf_front dac_dbuf_chk #(.CODE_W(CODE_W), .LOW_W(LOW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .bsel(bsel),
    .xfer_n(xfer_n), .din(din), .latch_code(latch_code),
    .dac_code(dac_code), .act_q(act_q)
);

// File: tb/sim_dac_dbuf_front.sv
`timescale 1ns/1ps
module sim_dac_dbuf_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, bsel = 1'b1, xfer_n = 1'b1;
    logic [9:0] din = '0;
    logic [9:0] latch_code, dac_code;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    dac_dbuf_front u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .bsel(bsel),
        .xfer_n(xfer_n), .din(din), .latch_code(latch_code), .dac_code(dac_code)
    );

    // {cs_n, wr_n, bsel, xfer_n, din, expected latch, expected dac}
    localparam int NV = 11;
    localparam logic [33:0] VEC [NV] = '{
        {4'b1011, 10'h3FF, 10'h000, 10'h000},  // R2 cs high
        {4'b0111, 10'h3FF, 10'h000, 10'h000},  // R3 wr high
        {4'b0011, 10'h2A5, 10'h2A5, 10'h000},  // R4 full load
        {4'b0001, 10'h0C0, 10'h2A4, 10'h000},  // R5 low bits from din[9:8]
        {4'b1000, 10'h3FF, 10'h2A4, 10'h2A4},  // R6 transfer without cs
        {4'b0010, 10'h155, 10'h155, 10'h2A4},  // R7 bsel high blocks transfer
        {4'b1100, 10'h000, 10'h155, 10'h2A4},  // R7 wr high blocks transfer
        {4'b0000, 10'h300, 10'h157, 10'h157},  // R8 flow-through
        {4'b0011, 10'h30C, 10'h30C, 10'h157},  // R9 first byte C3
        {4'b0001, 10'h200, 10'h30E, 10'h157},  // R9 second byte 80
        {4'b1000, 10'h000, 10'h30E, 10'h30E}   // R6 publish assembled code
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] ctl, input logic [9:0] d);
        {cs_n, wr_n, bsel, xfer_n} = ctl;
        din = d;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 latch in reset", latch_code, 10'h000);
        check("R1 dac in reset", dac_code, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 latch after release", latch_code, 10'h000);
        check("R1 dac after release", dac_code, 10'h000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][33:30], VEC[i][29:20]);
            check($sformatf("vector %0d latch", i), latch_code, VEC[i][19:10]);
            check($sformatf("vector %0d dac", i), dac_code, VEC[i][9:0]);
        end

        // R7: dac holds through a full load with transfer idle
        step(4'b0011, 10'h0F0);
        check("R7 latch loads", latch_code, 10'h0F0);
        check("R7 dac holds", dac_code, 10'h30E);

        // R5: two low-bit writes in a row keep the upper eight bits
        step(4'b0001, 10'h100);
        step(4'b0001, 10'h2FF);
        check("R5 repeated low write", latch_code, 10'h0F2);

        // R1: reset in the middle of operation clears both registers
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 latch mid reset", latch_code, 10'h000);
        check("R1 dac mid reset", dac_code, 10'h000);
        rst_n = 1'b1;
        step(4'b1111, 10'h000);

        // R8: flow-through from a full load then a combined write and transfer
        step(4'b0011, 10'h3FC);
        step(4'b0000, 10'h1FF);
        check("R8 flow latch", latch_code, 10'h3FD);
        check("R8 flow dac", dac_code, 10'h3FD);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule